// File: doc/BRIEF.md
# Edge and Level Interrupt Detector for an Eight-Line Input Bank

The block watches eight input pins and turns selected changes on them into one interrupt request. Software reaches it through a small byte-wide register port: an address, a write strobe, write data and combinational read data. Every register holds one bit per line, and bit n always belongs to line n. For each line, software picks level or edge sensitivity and a polarity. It can also enable the line, turn on an input filter and acknowledge a latched edge.

Each pin goes through a two-stage synchroniser first. It then passes through an optional stability filter, which is a small two-state machine per line. Its states are `DB_STEADY` and `DB_SETTLE`. The transition `DB_STEADY -> DB_SETTLE` is taken when the synchronised input first differs from the filtered value. `DB_SETTLE -> DB_STEADY` (abort) is taken when the input returns to the filtered value before the count completes. `DB_SETTLE -> DB_STEADY` (commit) is taken when the input has differed for the required number of clocks, and the filtered value then takes the new level. In edge mode, an edge of the selected direction on an enabled line is held in a latch until software acknowledges it. In level mode, the line reports whether its input currently matches the selected level. The interrupt output is the OR of every enabled line's status.

Both-edge operation is left to software. Software inverts the polarity bit after each acknowledge. The edge detector keeps tracking the input while a line is disabled or reconfigured, so this inversion never produces a spurious event.

Top module: `pinirq_ctrl`

## Requirements
- R1: The registers sit at these byte offsets: sensitivity 0x00 (bit 0 = level, 1 = edge), polarity 0x04 (bit 0 = low/falling, 1 = high/rising), acknowledge 0x08, enable 0x0C, masked status 0x10, raw status 0x14 and filter enable 0x18. The sensitivity, polarity, enable and filter registers read back what was written. The acknowledge register reads 0. Writes to the two status offsets change nothing. After reset, every writable register is 0.
- R2: Every pin passes through two flops. A pin change shows up in level status after the second rising clock edge, and not after the first.
- R3: A line in level mode reports raw status 1 exactly while its synchronised input equals its polarity bit.
- R4: A line in edge mode latches an event only on a transition of the selected direction. The latched event stays set after the pin returns to its former level.
- R5: Writing 1 to an acknowledge bit clears that line's latched event. Acknowledge bits written as 0 leave latched events untouched. A new edge in the same cycle as the acknowledge wins over the acknowledge.
- R6: Masked status equals raw status AND enable. The interrupt output is 1 exactly when any masked status bit is 1.
- R7: An edge that arrives while the line's enable bit is 0 is not latched, and it does not appear when the line is enabled later.
- R8: With filtering enabled, a line's filtered input takes a new value only after the synchronised input has held that value for 4 consecutive clocks. A pulse shorter than that is discarded.
- R9: With filtering disabled, a line's detection uses the synchronised input directly, so a 2-clock pulse is caught.
- R10: Enabling a line, or inverting its polarity, while its input is steady latches no event.
- R11: A line placed in level mode has its latched edge event cleared. A line returned to edge mode therefore starts with no pending event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data, one bit per line |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_in | input | 8 | Asynchronous input pins |
| irq_out | output | 1 | Interrupt request, OR of masked status |

## Verification
Several properties are checked on every clock by the bound checker. The interrupt output must equal the OR of raw status AND enable. A latch may rise only after an enabled edge of the selected direction. A line in level mode may hold no latched event. An acknowledged line may not keep its event unless a new edge arrived. A filtered value may change only after four matching synchronised samples. Some behaviour shows only in the bench's scenarios, because it needs a specific stimulus history: the exact two-edge synchroniser latency, the precise clock on which a filtered edge first becomes visible, register readback, ignored status writes, and the absence of events after enabling a line or inverting its polarity.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    // register byte offsets (software-visible map)
    localparam logic [4:0] OFS_SENSE  = 5'h00;
    localparam logic [4:0] OFS_POL    = 5'h04;
    localparam logic [4:0] OFS_ACK    = 5'h08;
    localparam logic [4:0] OFS_ENABLE = 5'h0C;
    localparam logic [4:0] OFS_MASKED = 5'h10;
    localparam logic [4:0] OFS_RAW    = 5'h14;
    localparam logic [4:0] OFS_FILTER = 5'h18;

    // per-line stability filter states
    typedef enum logic {
        DB_STEADY = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_e;

endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/pinirq_filter.sv
module pinirq_filter
    import pinirq_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    localparam int CNT_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STABLE_CYCLES - 1);

    db_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             out_q, out_n;

    // next-state and next-output decision
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        out_n   = out_q;
        unique case (state_q)
            DB_STEADY: begin
                if (din != out_q) begin
                    if (STABLE_CYCLES <= 1) begin
                        out_n = din;
                    end else begin
                        state_n = DB_SETTLE;
                        cnt_n   = CNT_W'(1);
                    end
                end
            end
            DB_SETTLE: begin
                if (din == out_q) begin
                    state_n = DB_STEADY;          // abort: glitch ended
                    cnt_n   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_n = DB_STEADY;          // commit: held long enough
                    cnt_n   = '0;
                    out_n   = din;
                end else begin
                    cnt_n = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_n = DB_STEADY;
                cnt_n   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DB_STEADY;
            cnt_q   <= '0;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            out_q   <= out_n;
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/pinirq_detect.sv
module pinirq_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    input  logic [WIDTH-1:0] edge_mode,
    input  logic [WIDTH-1:0] polarity,
    input  logic [WIDTH-1:0] enable,
    input  logic [WIDTH-1:0] ack_clr,
    output logic [WIDTH-1:0] edge_seen,
    output logic [WIDTH-1:0] latched,
    output logic [WIDTH-1:0] raw_status
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] latch_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic rise, fall, hit, keep;
        assign rise = level_in[i] & ~prev_q[i];
        assign fall = ~level_in[i] & prev_q[i];
        assign hit  = edge_mode[i] & (polarity[i] ? rise : fall);
        assign keep = latch_q[i] & ~ack_clr[i];
        assign edge_seen[i] = hit;

        // previous value always follows the input, whatever the config
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[i]  <= 1'b0;
                latch_q[i] <= 1'b0;
            end else begin
                prev_q[i]  <= level_in[i];
                latch_q[i] <= edge_mode[i] & (keep | (hit & enable[i]));
            end
        end

        assign raw_status[i] = edge_mode[i] ? latch_q[i]
                                            : ~(level_in[i] ^ polarity[i]);
    end

    assign latched = latch_q;

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
    import pinirq_pkg::*;
#(
    parameter int LINES         = 8,
    parameter int STABLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       reg_addr,
    input  logic             reg_we,
    input  logic [LINES-1:0] reg_wdata,
    output logic [LINES-1:0] reg_rdata,
    input  logic [LINES-1:0] pin_in,
    output logic             irq_out
);

    logic [LINES-1:0] mode_q, pol_q, en_q, filt_en_q;
    logic [LINES-1:0] sync_v, filt_v, det_v;
    logic [LINES-1:0] edge_v, latch_v, raw_v, masked_v, ack_v;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            pol_q     <= '0;
            en_q      <= '0;
            filt_en_q <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_SENSE:  mode_q    <= reg_wdata;
                OFS_POL:    pol_q     <= reg_wdata;
                OFS_ENABLE: en_q      <= reg_wdata;
                OFS_FILTER: filt_en_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // acknowledge is a strobe with no storage
    assign ack_v = (reg_we && reg_addr == OFS_ACK) ? reg_wdata : '0;

    pinirq_sync #(.WIDTH(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_v)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_filt
        pinirq_filter #(.STABLE_CYCLES(STABLE_CYCLES)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_v[i]),
            .dout  (filt_v[i])
        );
        assign det_v[i] = filt_en_q[i] ? filt_v[i] : sync_v[i];
    end

    pinirq_detect #(.WIDTH(LINES)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_in   (det_v),
        .edge_mode  (mode_q),
        .polarity   (pol_q),
        .enable     (en_q),
        .ack_clr    (ack_v),
        .edge_seen  (edge_v),
        .latched    (latch_v),
        .raw_status (raw_v)
    );

    assign masked_v = raw_v & en_q;
    assign irq_out  = |masked_v;

    // readback
    always_comb begin
        case (reg_addr)
            OFS_SENSE:  reg_rdata = mode_q;
            OFS_POL:    reg_rdata = pol_q;
            OFS_ENABLE: reg_rdata = en_q;
            OFS_MASKED: reg_rdata = masked_v;
            OFS_RAW:    reg_rdata = raw_v;
            OFS_FILTER: reg_rdata = filt_en_q;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
    parameter int LINES         = 8,
    parameter int STABLE_CYCLES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic [LINES-1:0] raw_v,
    input logic [LINES-1:0] en_q,
    input logic [LINES-1:0] mode_q,
    input logic [LINES-1:0] latch_v,
    input logic [LINES-1:0] edge_v,
    input logic [LINES-1:0] ack_v,
    input logic [LINES-1:0] sync_v,
    input logic [LINES-1:0] filt_v
);

    assert_irq_or_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == |(raw_v & en_q));

    assert_latch_needs_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_v & ~$past(latch_v) & ~$past(edge_v)) == '0);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_v & $past(ack_v & ~(edge_v & en_q))) == '0);

    assert_no_latch_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_v & ~$past(latch_v) & ~$past(en_q)) == '0);

    assert_level_no_latch_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_v & ~$past(mode_q)) == '0);

    if (STABLE_CYCLES == 4) begin : g_filt_chk
        assert_filter_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((filt_v ^ $past(filt_v)) &
             ((filt_v ^ $past(sync_v, 1)) | (filt_v ^ $past(sync_v, 2)) |
              (filt_v ^ $past(sync_v, 3)) | (filt_v ^ $past(sync_v, 4)))) == '0);
    end

endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(
    .LINES         (LINES),
    .STABLE_CYCLES (STABLE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_out (irq_out),
    .raw_v   (raw_v),
    .en_q    (en_q),
    .mode_q  (mode_q),
    .latch_v (latch_v),
    .edge_v  (edge_v),
    .ack_v   (ack_v),
    .sync_v  (sync_v),
    .filt_v  (filt_v)
);

// File: tb/pinirq_ctrl_test.sv
module pinirq_ctrl_test;

    localparam logic [4:0] A_SENSE = 5'h00, A_POL = 5'h04, A_ACK = 5'h08,
                           A_EN = 5'h0C, A_MASK = 5'h10, A_RAW = 5'h14,
                           A_FILT = 5'h18;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_in = '0;
    logic       irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit         is_irq;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    pinirq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pin_in),
        .irq_out   (irq_out)
    );

    always #4 clk = ~clk;

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {7'b0, irq_out} : reg_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        step(1);
        reg_we    = 1'b0;
    endtask

    task automatic chk_reg(input logic [4:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        reg_addr  = a;
        it.is_irq = 1'b0;
        it.exp    = e;
        it.tag    = tag;
        sb_q.push_back(it);
        step(1);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1;
        it.exp    = {7'b0, e};
        it.tag    = tag;
        sb_q.push_back(it);
        step(1);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // reset state, R1 / R3 / R6
        chk_reg(A_SENSE, 8'h00, "R1 reset sense");
        chk_reg(A_POL,   8'h00, "R1 reset polarity");
        chk_reg(A_EN,    8'h00, "R1 reset enable");
        chk_reg(A_FILT,  8'h00, "R1 reset filter");
        chk_reg(A_ACK,   8'h00, "R1 ack reads zero");
        chk_reg(A_RAW,   8'hFF, "R3 reset level-low raw");
        chk_reg(A_MASK,  8'h00, "R6 reset masked");
        chk_irq(1'b0, "R6 reset irq");

        // readback and ignored status writes, R1
        wr(A_SENSE, 8'hA5); chk_reg(A_SENSE, 8'hA5, "R1 sense readback");
        wr(A_POL,   8'h3C); chk_reg(A_POL,   8'h3C, "R1 polarity readback");
        wr(A_FILT,  8'h81); chk_reg(A_FILT,  8'h81, "R1 filter readback");
        wr(A_SENSE, 8'h00); wr(A_POL, 8'h00); wr(A_FILT, 8'h00);
        wr(A_RAW,  8'h00); chk_reg(A_RAW, 8'hFF, "R1 raw write ignored");
        wr(A_MASK, 8'hFF); chk_reg(A_MASK, 8'h00, "R1 masked write ignored");
        wr(A_EN,    8'h0F); chk_reg(A_EN, 8'h0F, "R1 enable readback");
        wr(A_EN,    8'h00);

        // synchroniser latency, R2
        wr(A_POL, 8'h01);
        pin_in = 8'h01;
        chk_reg(A_RAW, 8'hFE, "R2 not visible after one edge");
        chk_reg(A_RAW, 8'hFF, "R2 visible after two edges");

        // level mode with enable and irq, R3 / R6
        wr(A_EN, 8'h01);
        chk_reg(A_MASK, 8'h01, "R3 level high active");
        chk_irq(1'b1, "R6 irq from level line");
        pin_in = 8'h00;
        step(3);
        chk_reg(A_MASK, 8'h00, "R3 level released");
        chk_irq(1'b0, "R6 irq released");
        wr(A_EN, 8'h00); wr(A_POL, 8'h00);

        // rising edge on line 2, R4 / R5
        wr(A_SENSE, 8'h04); wr(A_POL, 8'h04); wr(A_EN, 8'h04);
        chk_reg(A_MASK, 8'h00, "R10 enable without edge");
        pin_in = 8'h04; step(4);
        chk_reg(A_MASK, 8'h04, "R4 rising edge latched");
        chk_irq(1'b1, "R6 irq from edge");
        pin_in = 8'h00; step(4);
        chk_reg(A_MASK, 8'h04, "R4 latch held after pin falls");
        wr(A_ACK, 8'hFB);
        chk_reg(A_MASK, 8'h04, "R5 zero ack bit keeps event");
        wr(A_ACK, 8'h04);
        chk_reg(A_MASK, 8'h00, "R5 ack clears event");
        chk_irq(1'b0, "R5 irq after ack");

        // falling edge on line 3 and polarity inversion, R4 / R10
        wr(A_EN, 8'h00);
        wr(A_SENSE, 8'h08); wr(A_POL, 8'h00); wr(A_EN, 8'h08);
        pin_in = 8'h08; step(4);
        chk_reg(A_MASK, 8'h00, "R4 rising ignored in falling mode");
        wr(A_POL, 8'h08); step(2);
        chk_reg(A_MASK, 8'h00, "R10 polarity flip no event");
        wr(A_POL, 8'h00); step(2);
        chk_reg(A_MASK, 8'h00, "R10 polarity flip back no event");
        pin_in = 8'h00; step(4);
        chk_reg(A_MASK, 8'h08, "R4 falling edge latched");
        wr(A_ACK, 8'h08);
        chk_reg(A_MASK, 8'h00, "R5 falling ack clears");

        // disabled line drops edges, R7
        wr(A_EN, 8'h00);
        wr(A_SENSE, 8'h10); wr(A_POL, 8'h10);
        pin_in = 8'h10; step(4);
        pin_in = 8'h00; step(4);
        wr(A_EN, 8'h10);
        chk_reg(A_MASK, 8'h00, "R7 edge while disabled not latched");
        chk_irq(1'b0, "R7 no irq after enable");

        // level mode clears latch, R11
        wr(A_EN, 8'h00);
        wr(A_SENSE, 8'h04); wr(A_POL, 8'h04); wr(A_EN, 8'h04);
        pin_in = 8'h04; step(4);
        chk_reg(A_MASK, 8'h04, "R11 event latched before mode change");
        wr(A_SENSE, 8'h00);
        chk_reg(A_MASK, 8'h04, "R3 level mode active-high");
        wr(A_SENSE, 8'h04);
        chk_reg(A_MASK, 8'h00, "R11 no pending event after return");
        wr(A_EN, 8'h00);
        pin_in = 8'h00; step(4);

        // filtered line 5: short pulse dropped, long one caught, R8
        wr(A_SENSE, 8'h20); wr(A_POL, 8'h20); wr(A_FILT, 8'h20); wr(A_EN, 8'h20);
        step(6);
        pin_in = 8'h20; step(2);
        pin_in = 8'h00; step(8);
        chk_reg(A_MASK, 8'h00, "R8 short pulse filtered");
        pin_in = 8'h20; step(5);
        chk_reg(A_MASK, 8'h00, "R8 not yet stable four clocks");
        chk_reg(A_MASK, 8'h20, "R8 edge after four stable clocks");
        wr(A_ACK, 8'h20);
        pin_in = 8'h00; step(8);
        wr(A_EN, 8'h00);

        // unfiltered line 6 catches the same short pulse, R9
        wr(A_SENSE, 8'h40); wr(A_POL, 8'h40); wr(A_FILT, 8'h00); wr(A_EN, 8'h40);
        pin_in = 8'h40; step(2);
        pin_in = 8'h00; step(4);
        chk_reg(A_MASK, 8'h40, "R9 short pulse caught unfiltered");
        chk_irq(1'b1, "R9 irq from short pulse");

        step(2);
        done = 1'b1;
        finish_run();
    end

endmodule